// File: doc/BRIEF.md
# Memory Card Host Cycle Sequencer

This block sits on the host side of a PC Card-style memory card socket. It takes one request at a time from a request/acknowledge interface and plays it out on the card's active-low strobes (card enable, output enable, write enable), its address bus and its data bus. Three kinds of cycle are supported: an attribute-space read, a configuration-register write and a common-space read. Each kind has its own timing profile. Every interval is written in nanoseconds and turned into clocks of the system clock by rounding up. The tri-state buffer is outside the block, so the data bus appears here as an output word, a drive enable and an input word.

Common-space reads may be stretched by the card through an active-low wait input. If the wait stays low past the allowed width plus a margin, the cycle is aborted and reported with an error. When the configured output-enable time of a common read already exceeds the maximum wait width, the wait input is ignored.

The controller has five named states. IDLE leaves all strobes high and accepts a request. SETUP drives the address with card enable low. STROBE holds output enable or write enable low for the timed interval. WAIT keeps output enable low while the card stretches. HOLD releases the strobe but keeps the address and card enable.

The transitions are:
- IDLE→SETUP when a valid request arrives.
- SETUP→STROBE when the setup count ends.
- STROBE→HOLD when the count ends and no stretch is needed.
- STROBE→WAIT when the count ends with the wait input low on a common read.
- WAIT→HOLD when the wait input is released.
- WAIT→IDLE when the wait timeout expires (abort).
- HOLD→IDLE when the hold count ends (acknowledge).

Top module: `card_cycle_seq`

## Requirements
- R1: After reset, `card_ce_n`, `card_oe_n` and `card_we_n` are high, `card_data_oe` is low, `req_ready` is high and `ack_valid` is low.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_kind` is coded as follows: 0 is an attribute read, 1 is a configuration write, 2 is a common read. Code 3 is ignored: no strobe moves, `req_ready` stays high and no acknowledge follows.
- R3: An attribute read (10 ns clock, defaults) works as follows. Card enable and the address are driven for 3 clocks before output enable falls. Output enable then stays low for 27 clocks. Data is captured at the edge that ends the last output-enable-low clock, 300 ns after the address became valid. This is followed by 2 hold clocks.
- R4: A configuration write works as follows. Write data is driven from the first cycle. After 3 setup clocks, write enable is low for 19 clocks. After that, the address, data, drive enable and card enable are held for 3 recovery clocks, and then the drive enable drops.
- R5: A common read with the wait input high works as follows. There are 3 setup clocks, then output enable is low for 13 clocks (125 ns). Data is captured at the end of the last low clock, and card enable and the address are kept for 2 clocks after output enable rises.
- R6: If `card_wait_n` is low in the last timed output-enable clock of a common read, output enable stays low. Data is captured at the end of the first clock in which `card_wait_n` is seen high, and the 2 hold clocks follow.
- R7: If the stretch lasts 40 clocks (350 ns plus a 50 ns margin; 3000 ns in extended mode), the cycle is aborted. All strobes are high from the next clock, and the acknowledge carries `ack_err` = 1.
- R8: When `CM_OE_NS` exceeds the maximum wait width, a low `card_wait_n` has no effect. Output enable is low for exactly ceil(`CM_OE_NS`/period) clocks.
- R9: Each cycle ends with one `ack_valid` pulse in the first IDLE clock. In that clock all strobes are high, so consecutive cycles are always separated by released strobes.
- R10: `card_data_oe` is high only during configuration writes, and never while `card_oe_n` is low.
- R11: While `card_ce_n` stays low, `card_addr` does not change. While `card_data_oe` stays high, `card_data_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind code (see R2) |
| req_addr | input | ADDR_W | Card address for the request |
| req_wdata | input | DATA_W | Write data for a configuration write |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| ack_valid | output | 1 | One-clock completion pulse |
| ack_err | output | 1 | Completion was a wait timeout abort |
| ack_rdata | output | DATA_W | Data captured by the last read |
| card_addr | output | ADDR_W | Card address bus |
| card_ce_n | output | 1 | Card enable, active low |
| card_oe_n | output | 1 | Output enable, active low |
| card_we_n | output | 1 | Write enable, active low |
| card_wait_n | input | 1 | Card stretch request, active low |
| card_data_o | output | DATA_W | Host data toward the card |
| card_data_oe | output | 1 | Host data driver enable |
| card_data_i | input | DATA_W | Data bus as seen from the card |

## Verification
All outputs are Moore functions of registered state. A request taken at one edge therefore shows in the strobes one clock later, and each phase lasts exactly its clock count. The acknowledge appears one clock after the last hold clock, or one clock after the fortieth wait clock on an abort. The bench derives every phase boundary from the nanosecond figures in the requirements and compares the full strobe vector at each falling edge. It drives the card data bus with the correct value only in the single clock where capture is due, so a capture one clock early or late returns the wrong word. The wait input is held low up to chosen clock numbers to land exactly on the stretch boundary, a long stretch and the timeout.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    typedef enum logic [1:0] {
        K_ATTR_RD = 2'd0,
        K_CFG_WR  = 2'd1,
        K_COM_RD  = 2'd2,
        K_RSVD    = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SETUP  = 3'd1,
        S_STROBE = 3'd2,
        S_WAIT   = 3'd3,
        S_HOLD   = 3'd4
    } seq_state_e;

    // nanoseconds to clocks, rounded up
    function automatic int ns2clk(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_tick_cnt.sv
module seq_tick_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // a loaded count never grows except by a fresh load
    p_cnt_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load && $past(!load) && ($past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/seq_wait_guard.sv
module seq_wait_guard #(
    parameter int LIMIT = 40,
    parameter int W     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active)
            cnt_q <= '0;
        else if (cnt_q != W'(LIMIT - 1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = active && (cnt_q == W'(LIMIT - 1));

    p_guard_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT - 1));

    p_guard_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt_q == '0);

endmodule

// File: rtl/card_cycle_seq.sv
module card_cycle_seq
    import card_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 10,
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter bit EXT_WAIT       = 1'b0,
    parameter int CM_OE_NS       = 125,
    parameter int WAIT_MARGIN_NS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack_valid,
    output logic              ack_err,
    output logic [DATA_W-1:0] ack_rdata,
    output logic [ADDR_W-1:0] card_addr,
    output logic              card_ce_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    input  logic              card_wait_n,
    output logic [DATA_W-1:0] card_data_o,
    output logic              card_data_oe,
    input  logic [DATA_W-1:0] card_data_i
);
    // timing profile, all in clocks
    localparam int T_SU     = ns2clk(30, CLK_PERIOD_NS);
    localparam int T_REC    = ns2clk(30, CLK_PERIOD_NS);
    localparam int T_AH     = ns2clk(20, CLK_PERIOD_NS);
    localparam int T_AR_OE  = imax(ns2clk(150, CLK_PERIOD_NS),
                                   imax(ns2clk(300, CLK_PERIOD_NS) - T_SU, 1));
    localparam int T_WR_WE  = imax(ns2clk(150, CLK_PERIOD_NS),
                                   imax(ns2clk(80, CLK_PERIOD_NS),
                                        ns2clk(250, CLK_PERIOD_NS) - T_SU - T_REC));
    localparam int T_CM_OE  = imax(imax(ns2clk(125, CLK_PERIOD_NS), ns2clk(CM_OE_NS, CLK_PERIOD_NS)),
                                   ns2clk(35, CLK_PERIOD_NS) + 1);
    localparam int WAIT_MAX_NS = EXT_WAIT ? 3000 : 350;
    localparam int T_WTO    = ns2clk(WAIT_MAX_NS + WAIT_MARGIN_NS, CLK_PERIOD_NS);
    localparam bit WAIT_IGNORE = (CM_OE_NS > WAIT_MAX_NS);
    localparam int T_MAX    = imax(imax(T_AR_OE, T_WR_WE), imax(T_CM_OE, imax(T_SU, imax(T_REC, T_AH))));
    localparam int CNT_W    = $clog2(T_MAX + 1);
    localparam int WTO_W    = $clog2(T_WTO + 1);

    seq_state_e        state_q, state_d;
    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q, err_q;

    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              tick_done;
    logic              wait_expired;
    logic              accept, sample, finish, abort;
    logic [CNT_W-1:0]  strobe_len, hold_len;

    seq_tick_cnt #(.W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (tick_done)
    );

    seq_wait_guard #(.LIMIT(T_WTO), .W(WTO_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == S_WAIT),
        .expired (wait_expired)
    );

    // per-kind phase lengths, minus one for the down counter
    always_comb begin
        unique case (kind_q)
            K_ATTR_RD: begin strobe_len = CNT_W'(T_AR_OE - 1); hold_len = CNT_W'(T_AH - 1);  end
            K_CFG_WR:  begin strobe_len = CNT_W'(T_WR_WE - 1); hold_len = CNT_W'(T_REC - 1); end
            K_COM_RD:  begin strobe_len = CNT_W'(T_CM_OE - 1); hold_len = CNT_W'(T_AH - 1);  end
            default:   begin strobe_len = '0;                  hold_len = '0;                end
        endcase
    end

    assign accept = (state_q == S_IDLE) && req_valid && (cyc_kind_e'(req_kind) != K_RSVD);

    // next state
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        sample  = 1'b0;
        finish  = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = S_SETUP;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(T_SU - 1);
                end
            end
            S_SETUP: begin
                if (tick_done) begin
                    state_d = S_STROBE;
                    ld      = 1'b1;
                    ld_val  = strobe_len;
                end
            end
            S_STROBE: begin
                if (tick_done) begin
                    if (kind_q == K_COM_RD && !WAIT_IGNORE && !card_wait_n) begin
                        state_d = S_WAIT;
                    end else begin
                        state_d = S_HOLD;
                        ld      = 1'b1;
                        ld_val  = hold_len;
                        sample  = (kind_q != K_CFG_WR);
                    end
                end
            end
            S_WAIT: begin
                if (card_wait_n) begin
                    state_d = S_HOLD;
                    ld      = 1'b1;
                    ld_val  = hold_len;
                    sample  = 1'b1;
                end else if (wait_expired) begin
                    state_d = S_IDLE;
                    abort   = 1'b1;
                end
            end
            S_HOLD: begin
                if (tick_done) begin
                    state_d = S_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_ATTR_RD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= finish | abort;
            err_q   <= abort;
            if (accept) begin
                kind_q  <= cyc_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample)
                rdata_q <= card_data_i;
        end
    end

    // strobe outputs, decoded from state and kind
    always_comb begin
        card_ce_n    = 1'b1;
        card_oe_n    = 1'b1;
        card_we_n    = 1'b1;
        card_data_oe = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_SETUP: begin
                card_ce_n    = 1'b0;
                card_data_oe = (kind_q == K_CFG_WR);
            end
            S_STROBE: begin
                card_ce_n    = 1'b0;
                card_oe_n    = (kind_q == K_CFG_WR);
                card_we_n    = (kind_q != K_CFG_WR);
                card_data_oe = (kind_q == K_CFG_WR);
            end
            S_WAIT: begin
                card_ce_n = 1'b0;
                card_oe_n = 1'b0;
            end
            S_HOLD: begin
                card_ce_n    = 1'b0;
                card_data_oe = (kind_q == K_CFG_WR);
            end
            default: ;
        endcase
    end

    assign req_ready   = (state_q == S_IDLE);
    assign ack_valid   = ack_q;
    assign ack_err     = err_q;
    assign ack_rdata   = rdata_q;
    assign card_addr   = addr_q;
    assign card_data_o = wdata_q;

    // checks beside the logic they guard
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> card_ce_n && card_oe_n && card_we_n);

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!card_oe_n && !card_we_n));

    p_no_drive_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !card_oe_n |-> !card_data_oe);

    p_strobe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_oe_n || !card_we_n) |-> !card_ce_n);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !card_ce_n && $past(!card_ce_n) |-> $stable(card_addr));

    p_wdata_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        card_data_oe && $past(card_data_oe) |-> $stable(card_data_o));

    p_abort_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> ack_valid && card_ce_n);

endmodule

// File: tb/card_cycle_seq_tb.sv
`timescale 1ns/1ps
module card_cycle_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 8;

    function automatic int cdiv(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    // expected clocks, taken from the requirement figures
    localparam int E_SU    = cdiv(30);
    localparam int E_AR    = cdiv(300) - E_SU;
    localparam int E_WR    = cdiv(250) - 2 * cdiv(30);
    localparam int E_CM    = cdiv(125);
    localparam int E_AH    = cdiv(20);
    localparam int E_REC   = cdiv(30);
    localparam int E_WTO   = cdiv(350 + 50);
    localparam int E_IGN   = cdiv(400);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, ack_valid, ack_err;
    logic [DW-1:0] ack_rdata;
    logic [AW-1:0] card_addr;
    logic          card_ce_n, card_oe_n, card_we_n;
    logic          card_wait_n = 1'b1;
    logic [DW-1:0] card_data_o;
    logic          card_data_oe;
    logic [DW-1:0] card_data_i = '0;

    card_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ack_valid(ack_valid), .ack_err(ack_err), .ack_rdata(ack_rdata),
        .card_addr(card_addr), .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
        .card_wait_n(card_wait_n), .card_data_o(card_data_o), .card_data_oe(card_data_oe),
        .card_data_i(card_data_i)
    );

    // second instance whose output-enable time exceeds the wait width
    logic          i_req_valid = 1'b0;
    logic          i_ready, i_ack, i_err;
    logic [DW-1:0] i_rdata, i_do;
    logic [AW-1:0] i_addr;
    logic          i_ce_n, i_oe_n, i_we_n, i_doe;

    card_cycle_seq #(.CM_OE_NS(400)) u_dut_ign (
        .clk(clk), .rst_n(rst_n),
        .req_valid(i_req_valid), .req_kind(2'd2), .req_addr(11'h012), .req_wdata(8'h00),
        .req_ready(i_ready), .ack_valid(i_ack), .ack_err(i_err), .ack_rdata(i_rdata),
        .card_addr(i_addr), .card_ce_n(i_ce_n), .card_oe_n(i_oe_n), .card_we_n(i_we_n),
        .card_wait_n(1'b0), .card_data_o(i_do), .card_data_oe(i_doe),
        .card_data_i(8'h77)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // packed strobe view: ce oe we doe ready ack err
    function automatic logic [6:0] view();
        return {card_ce_n, card_oe_n, card_we_n, card_data_oe, req_ready, ack_valid, ack_err};
    endfunction

    // behavioural reference for one cycle; call at a falling edge in IDLE
    task automatic run_txn(input string tag, input logic [1:0] kind, input logic [AW-1:0] addr,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rd, input int low_until);
        int strobe, hold, w, se, last, ackc, samp;
        bit abort, is_wr, is_rd;
        logic [6:0] exp;
        is_wr  = (kind == 2'd1);
        is_rd  = !is_wr;
        strobe = (kind == 2'd0) ? E_AR : (is_wr ? E_WR : E_CM);
        hold   = (kind == 2'd0) ? E_AH : (is_wr ? E_REC : E_AH);
        se     = E_SU + strobe;
        w      = 0;
        abort  = 1'b0;
        if (kind == 2'd2 && low_until >= se) begin
            w = low_until + 1 - se;
            if (w > E_WTO) begin
                w     = E_WTO;
                abort = 1'b1;
                hold  = 0;
            end
        end
        last = se + w + hold;
        ackc = last + 1;
        samp = (is_rd && !abort) ? se + w : -1;
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        for (int n = 1; n <= ackc; n++) begin
            @(negedge clk);
            req_valid   = 1'b0;
            card_wait_n = !(low_until > 0 && n <= low_until);
            card_data_i = (n == samp) ? rd : ~rd;
            exp = {!(n <= last),
                   !(is_rd && n > E_SU && n <= se + w),
                   !(is_wr && n > E_SU && n <= se),
                   is_wr && n <= last,
                   n > last,
                   n == ackc,
                   abort && n == ackc};
            check({tag, " strobes"}, 32'(view()), 32'(exp));
            if (n <= last) check({tag, " addr"}, 32'(card_addr), 32'(addr));
            if (is_wr && n <= last) check({tag, " wdata"}, 32'(card_data_o), 32'(wd));
            if (n == ackc && samp > 0) check({tag, " rdata"}, 32'(ack_rdata), 32'(rd));
        end
        card_wait_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int oe_cnt, ack_at, cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", 32'(view()), 32'(7'b1110100));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'(view()), 32'(7'b1110100));

        // R2: reserved code is ignored
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 11'h7FF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 reserved ignored", 32'(view()), 32'(7'b1110100));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 no ack after reserved", 32'(view()), 32'(7'b1110100));

        run_txn("R3 attr read",          2'd0, 11'h155, 8'h00, 8'hA5, 0);
        run_txn("R4 cfg write",          2'd1, 11'h200, 8'h3C, 8'h00, 0);
        // R9: back-to-back, the ack clock is the release gap
        run_txn("R9 read after write",   2'd0, 11'h0AA, 8'h00, 8'h5A, 0);
        run_txn("R5 common read",        2'd2, 11'h3F0, 8'h00, 8'hC3, 0);
        run_txn("R6 early wait no stretch", 2'd2, 11'h001, 8'h00, 8'h96, 10);
        run_txn("R6 stretch one clock",  2'd2, 11'h002, 8'h00, 8'h69, E_SU + E_CM);
        run_txn("R6 stretch ten clocks", 2'd2, 11'h004, 8'h00, 8'h1E, E_SU + E_CM + 9);
        run_txn("R6 stretch at limit",   2'd2, 11'h008, 8'h00, 8'hE1, E_SU + E_CM + E_WTO - 1);
        run_txn("R7 wait timeout",       2'd2, 11'h010, 8'h00, 8'h00, 200);
        run_txn("R7 recovery after abort", 2'd2, 11'h020, 8'h00, 8'h81, 0);
        run_txn("R10 write drive",       2'd1, 11'h040, 8'hF0, 8'h00, 0);

        // R8: ignored wait on the long-strobe instance
        i_req_valid = 1'b1;
        @(posedge clk);
        oe_cnt = 0; ack_at = 0;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            i_req_valid = 1'b0;
            if (!i_oe_n) oe_cnt++;
            if (i_ack && ack_at == 0) ack_at = n;
        end
        cyc = E_SU + E_IGN + E_AH + 1;
        check("R8 oe low clocks", 32'(oe_cnt), 32'(E_IGN));
        check("R8 ack clock", 32'(ack_at), 32'(cyc));
        check("R8 no error", 32'(i_err), 32'(0));
        check("R8 data", 32'(i_rdata), 32'(8'h77));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule